// File: doc/BRIEF.md
# Slave Parallel Bus Strobe Generator

This block is the output stage on the receiving side of a serial display link. Each word the deserialiser delivers is placed on a 16-bit parallel bus for a display driver, together with an access framed by a select pin and a strobe pin. There are two bus styles. In write-strobe style the write pin pulses and chip select frames the access. In enable-strobe style the chip select pulses and the read/write pin frames it. The strobe is low for a fixed number of link-clock cycles, whatever the timing of the words on the serial side.

A one-entry buffer holds a word that arrives while an access is still running, so accesses can run back to back. The block also drives a reference clock for the display side. It divides the link clock by a value chosen with a 3-bit code. That value need not be a power of two, and code 000 is reserved.

Top module: `pbus_strobe_gen`

## Requirements
- R1: With `bus_mode`=0 (write-strobe style), each word drives `bus_wr_n` low for exactly 3 link cycles. `bus_cs_n` is low for 5 cycles: from one cycle before the strobe falls until one cycle after it rises. The access begins the cycle after `rx_valid` is sampled high.
- R2: With `bus_mode`=1 (enable-strobe style), each word drives `bus_cs_n` low for exactly 3 link cycles. `bus_wr_n` is low for 5 cycles: from one cycle before the strobe falls until one cycle after it rises.
- R3: Each clock edge that samples `rx_valid` high delivers one word. The strobe width stays 3 cycles whatever the spacing between words.
- R4: `bus_data` carries the new word from the first framed cycle. It stays unchanged through the strobe and through the cycle after the strobe rises. Between accesses it keeps the last word.
- R5: A word that arrives during an access is held in a one-entry buffer. Its access starts the cycle after the current access ends, so two accesses are 5 cycles apart. A word that arrives while the buffer is already full is discarded.
- R6: `clk_out` has a period of N link cycles, where N is set by `div_code`: 001→2, 010→4, 011→6, 100→7, 101→8, 110→9, 111→10.
- R7: Each period of `clk_out` has a high phase of floor(N/2) cycles and a low phase of the remaining cycles, so an odd N gives a high phase one cycle shorter than the low phase.
- R8: When `div_code` is 000 (reserved), `clk_out` stays low and `cfg_err` is high. `cfg_err` is low for every other code.
- R9: While `rst_n` is low, and on the first cycle after it, `bus_cs_n` and `bus_wr_n` are high, `bus_data` is zero and `clk_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received word is present this cycle |
| rx_data | input | 16 | Received word |
| bus_mode | input | 1 | 0: write-strobe style, 1: enable-strobe style |
| div_code | input | 3 | Output clock divisor code |
| bus_data | output | 16 | Parallel bus data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe (mode 0) or read/write level (mode 1), active low |
| clk_out | output | 1 | Divided reference clock |
| cfg_err | output | 1 | Reserved divisor code selected |

## Verification
The embedded assertions check, on every cycle, the properties that hold at all times. These are that the strobe low run is exactly three cycles, that the strobe always lies inside the framing signal, that the data stays still while the strobe is low and on the cycle it rises, that the buffer is never popped while empty, and that the reserved code keeps the clock low. Only the bench scenarios can show the rest. That covers which pin pulses in each bus style, the latency from `rx_valid`, the back-to-back hand-off from the buffer, the discarding of a third word, and the high and low phase lengths for every divisor code.

// File: rtl/pbsg_pkg.sv
// Package pbsg_pkg
// Purpose : shared types and the divisor decode for the strobe generator.
// Assumes : divisor codes are 3 bits wide; the largest divisor fits in DIV_W bits.
package pbsg_pkg;

    localparam int DIV_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_t;

    // Map a divisor code to its division ratio; code 0 is reserved and maps to 0.
    function automatic logic [DIV_W-1:0] divisor_of(input logic [2:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            3'd1:    r = DIV_W'(2);
            3'd2:    r = DIV_W'(4);
            3'd3:    r = DIV_W'(6);
            3'd4:    r = DIV_W'(7);
            3'd5:    r = DIV_W'(8);
            3'd6:    r = DIV_W'(9);
            3'd7:    r = DIV_W'(10);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pbsg_word_buf.sv
// Module  : pbsg_word_buf
// Purpose : one-entry holding register for a word that arrives mid-access.
// Assumes : a push while full is dropped unless a pop happens in the same cycle,
//           in which case the pushed word replaces the popped one.
module pbsg_word_buf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic              full,
    output logic [DATA_W-1:0] dout
);

    logic              full_q;
    logic [DATA_W-1:0] word_q;

    // Track occupancy and capture a pushed word when there is room.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            word_q <= '0;
        end else begin
            if (pop) begin
                full_q <= 1'b0;
            end
            if (push && (!full_q || pop)) begin
                word_q <= din;
                full_q <= 1'b1;
            end
        end
    end

    assign full = full_q;
    assign dout = word_q;

    AST_BUF_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> full_q); // R5

endmodule

// File: rtl/pbsg_strobe_seq.sv
// Module  : pbsg_strobe_seq
// Purpose : runs one bus access per word as a sequence of setup, strobe and hold.
//           The setup and hold phases are one cycle each and the strobe phase is
//           STROBE_CYC cycles. frame_n is low for the whole access; strobe_n is
//           low only in the strobe phase.
// Assumes : rx_valid marks one word per cycle; the bus style is mapped outside.
module pbsg_strobe_seq
    import pbsg_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int STROBE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              frame_n,
    output logic              strobe_n,
    output logic [DATA_W-1:0] bus_data
);

    localparam int CNT_W = $clog2(STROBE_CYC + 1);
    localparam int RUN_W = $clog2(STROBE_CYC + 2);

    seq_state_t        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;
    logic              buf_full;
    logic [DATA_W-1:0] buf_dout;
    logic              launch;
    logic              buf_push;
    logic              buf_pop;
    logic [DATA_W-1:0] next_word;

    // Decide whether a new access starts and which word it carries.
    always_comb begin
        launch    = ((st_q == ST_IDLE) || (st_q == ST_HOLD)) && (buf_full || rx_valid);
        next_word = buf_full ? buf_dout : rx_data;
        buf_pop   = launch && buf_full;
        buf_push  = rx_valid && !(launch && !buf_full);
    end

    pbsg_word_buf #(
        .DATA_W (DATA_W)
    ) i_word_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (buf_push),
        .pop   (buf_pop),
        .din   (rx_data),
        .full  (buf_full),
        .dout  (buf_dout)
    );

    // Step the access phases and count the strobe cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE, ST_HOLD: begin
                    st_q  <= launch ? ST_SETUP : ST_IDLE;
                    cnt_q <= '0;
                end
                ST_SETUP: begin
                    st_q  <= ST_STROBE;
                    cnt_q <= '0;
                end
                default: begin
                    if (cnt_q == CNT_W'(STROBE_CYC - 1)) begin
                        st_q  <= ST_HOLD;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Load the bus data register when an access starts; otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (launch) begin
            data_q <= next_word;
        end
    end

    assign frame_n  = (st_q == ST_IDLE);
    assign strobe_n = (st_q != ST_STROBE);
    assign bus_data = data_q;

    // Length of the current strobe low run, for the width check.
    logic [RUN_W-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (strobe_n) begin
            low_run_q <= '0;
        end else begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n) |-> (low_run_q == RUN_W'(STROBE_CYC))); // R3
    AST_STROBE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> (low_run_q < RUN_W'(STROBE_CYC))); // R1
    AST_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> !frame_n); // R2
    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> $stable(bus_data)); // R4
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n) |-> $stable(bus_data)); // R4

endmodule

// File: rtl/pbsg_clk_div.sv
// Module  : pbsg_clk_div
// Purpose : divides the link clock by the ratio chosen with the code. Each
//           period has floor(N/2) high cycles followed by the remaining low cycles.
// Assumes : the code may change at any time; the counter wraps into range at once.
//           Code 0 is reserved: the clock is held low and the error flag is raised.
module pbsg_clk_div
    import pbsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] code,
    output logic       clk_out,
    output logic       cfg_err
);

    logic [DIV_W-1:0] div_n;
    logic [DIV_W-1:0] half_n;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_nxt;
    logic             reserved;
    logic             clk_q;
    logic             err_q;

    // Decode the ratio and work out the next phase count.
    always_comb begin
        div_n    = divisor_of(code);
        half_n   = div_n >> 1;
        reserved = (code == 3'd0);
        cnt_nxt  = (cnt_q >= (div_n - DIV_W'(1))) ? '0 : (cnt_q + DIV_W'(1));
    end

    // Advance the phase counter and register the clock level and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
            err_q <= 1'b0;
        end else if (reserved) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
            err_q <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            clk_q <= (cnt_nxt < half_n);
            err_q <= 1'b0;
        end
    end

    assign clk_out = clk_q;
    assign cfg_err = err_q;

    AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !clk_out); // R8
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < DIV_W'(10)); // R6

endmodule

// File: rtl/pbus_strobe_gen.sv
// Module  : pbus_strobe_gen
// Purpose : top of the strobe generator. It maps the access frame and strobe onto
//           the select and write pins for the chosen bus style and drives the
//           divided reference clock.
// Assumes : bus_mode is stable while an access is running.
module pbus_strobe_gen
    import pbsg_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int STROBE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              bus_mode,
    input  logic [2:0]        div_code,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              clk_out,
    output logic              cfg_err
);

    logic frame_n;
    logic strobe_n;

    pbsg_strobe_seq #(
        .DATA_W     (DATA_W),
        .STROBE_CYC (STROBE_CYC)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .frame_n  (frame_n),
        .strobe_n (strobe_n),
        .bus_data (bus_data)
    );

    pbsg_clk_div i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (div_code),
        .clk_out (clk_out),
        .cfg_err (cfg_err)
    );

    // Route frame and strobe onto the pins for the selected bus style.
    always_comb begin
        if (bus_mode) begin
            bus_cs_n = strobe_n;
            bus_wr_n = frame_n;
        end else begin
            bus_cs_n = frame_n;
            bus_wr_n = strobe_n;
        end
    end

    AST_WSTYLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mode && !bus_wr_n) |-> !bus_cs_n); // R1
    AST_ESTYLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode && !bus_cs_n) |-> !bus_wr_n); // R2

endmodule

// File: tb/test_pbus_strobe_gen.sv
// Directed bench for pbus_strobe_gen; one task per scenario.
module test_pbus_strobe_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_data = '0;
    logic        bus_mode = 1'b0;
    logic [2:0]  div_code = 3'd1;
    logic [15:0] bus_data;
    logic        bus_cs_n;
    logic        bus_wr_n;
    logic        clk_out;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pbus_strobe_gen i_pbus_strobe_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .bus_mode (bus_mode),
        .div_code (div_code),
        .bus_data (bus_data),
        .bus_cs_n (bus_cs_n),
        .bus_wr_n (bus_wr_n),
        .clk_out  (clk_out),
        .cfg_err  (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check one cycle of an access: i=1 setup, 2..4 strobe, 5 hold, 6 idle.
    task automatic chk_cycle(input bit mode, input int i, input logic [15:0] d, input string req);
        bit frame_low  = (i >= 1 && i <= 5);
        bit strobe_low = (i >= 2 && i <= 4);
        bit exp_cs = mode ? !strobe_low : !frame_low;
        bit exp_wr = mode ? !frame_low  : !strobe_low;
        chk(bus_cs_n === exp_cs, {req, " cs_n"}, int'(bus_cs_n), int'(exp_cs));
        chk(bus_wr_n === exp_wr, {req, " wr_n"}, int'(bus_wr_n), int'(exp_wr));
        chk(bus_data === d, {req, " R4 data"}, int'(bus_data), int'(d));
    endtask

    task automatic one_access(input bit mode, input logic [15:0] d, input string req);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = d;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_data  = 16'hDEAD;
        for (int i = 1; i <= 6; i++) begin
            if (i > 1) @(negedge clk);
            chk_cycle(mode, i, d, req);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus_cs_n === 1'b1, "R9 cs_n in reset", int'(bus_cs_n), 1);
        chk(bus_wr_n === 1'b1, "R9 wr_n in reset", int'(bus_wr_n), 1);
        chk(bus_data === 16'h0, "R9 data in reset", int'(bus_data), 0);
        chk(clk_out === 1'b0, "R9 clk_out in reset", int'(clk_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cs_n === 1'b1 && bus_wr_n === 1'b1, "R9 idle after reset", int'({bus_cs_n, bus_wr_n}), 3);
    endtask

    task automatic t_write_style();
        bus_mode = 1'b0;
        one_access(1'b0, 16'hA5C3, "R1");
        one_access(1'b0, 16'h0001, "R1");
    endtask

    task automatic t_enable_style();
        bus_mode = 1'b1;
        one_access(1'b1, 16'h5A3C, "R2");
        one_access(1'b1, 16'hFFFF, "R2");
        bus_mode = 1'b0;
    endtask

    task automatic t_spacing();
        // Words with long and short gaps between them all get a 3-cycle strobe.
        one_access(1'b0, 16'h1234, "R3 gap");
        repeat (9) @(negedge clk);
        one_access(1'b0, 16'h4321, "R3 gap");
        one_access(1'b0, 16'h0F0F, "R3 gap");
    endtask

    task automatic t_buffer();
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 16'h1111;
        @(negedge clk);
        rx_data = 16'h2222;
        chk_cycle(1'b0, 1, 16'h1111, "R5 first");
        @(negedge clk);
        rx_data = 16'h3333;
        chk_cycle(1'b0, 2, 16'h1111, "R5 first");
        @(negedge clk);
        rx_valid = 1'b0; rx_data = 16'h0;
        chk_cycle(1'b0, 3, 16'h1111, "R5 first");
        for (int i = 4; i <= 5; i++) begin
            @(negedge clk);
            chk_cycle(1'b0, i, 16'h1111, "R5 first");
        end
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            chk_cycle(1'b0, i, 16'h2222, "R5 buffered");
        end
        repeat (4) @(negedge clk);
        chk(bus_cs_n === 1'b1 && bus_data === 16'h2222, "R5 third word dropped",
            int'(bus_data), 16'h2222);
    endtask

    task automatic t_divider(input logic [2:0] code, input int n);
        int hi = 0;
        int lo = 0;
        div_code = code;
        repeat (25) @(negedge clk);
        while (clk_out !== 1'b0) @(negedge clk);
        while (clk_out !== 1'b1) @(negedge clk);
        while (clk_out === 1'b1) begin hi++; @(negedge clk); end
        while (clk_out === 1'b0) begin lo++; @(negedge clk); end
        chk(hi + lo == n, "R6 period", hi + lo, n);
        chk(hi == n / 2, "R7 high phase", hi, n / 2);
        chk(lo == n - n / 2, "R7 low phase", lo, n - n / 2);
        chk(cfg_err === 1'b0, "R8 no error on valid code", int'(cfg_err), 0);
    endtask

    task automatic t_reserved();
        int highs = 0;
        div_code = 3'd0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            if (clk_out !== 1'b0) highs++;
            @(negedge clk);
        end
        chk(highs == 0, "R8 clock held low", highs, 0);
        chk(cfg_err === 1'b1, "R8 error flag", int'(cfg_err), 1);
        div_code = 3'd1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write_style();
        t_enable_style();
        t_spacing();
        t_buffer();
        t_divider(3'd1, 2);
        t_divider(3'd2, 4);
        t_divider(3'd3, 6);
        t_divider(3'd4, 7);
        t_divider(3'd5, 8);
        t_divider(3'd6, 9);
        t_divider(3'd7, 10);
        t_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule